// File: doc/BRIEF.md
# Set-Associative Cache Controller with Victim Buffer

This block is the tag and state side of a write-back, write-allocate, set-associative first-level cache. A small fully associative victim buffer sits beside it. The CPU side presents one read or write request at a time over a valid/ready handshake. The controller sorts each request into one of three cases:

- **Hit:** the line is in the L1 set.
- **Swap:** the line misses the L1 set but is found in the victim buffer, and the two lines trade places.
- **Miss:** the line is in neither structure. The controller fetches it from the next memory level, first writing back a dirty line that has to make room.

Only tags, valid bits, dirty bits and age counters are held; no data is stored. The next level is a single request/acknowledge channel that carries line-aligned addresses. A write flag on that channel tells a writeback from a refill read.

Six event counters record:

- reads and writes accepted;
- read misses and write misses;
- writebacks;
- victim swaps.

They let the rest of the system measure miss behaviour. Setting the victim-buffer entry count to zero gives a plain set-associative cache that evicts straight to the next level.

Top module: `l1vb_cache`

## Requirements
- R1: An address splits into an offset (the low log2(BLOCK_BYTES) bits), a set index (the next log2(SETS) bits) and a tag (the remaining upper bits). Every next-level address is a line address, with its offset bits forced to zero.
- R2: After reset every L1 way and every victim entry is invalid and clean, all six counters read zero, `req_ready` is 1 and `mem_req_valid` is 0.
- R3: A request whose tag matches a valid way of its set makes no next-level request, and `req_ready` is high again on the cycle after acceptance. A write hit marks the line dirty, so the line is written back when it is later evicted.
- R4: On an L1 miss that matches a valid victim entry (whose tag is the address with only its offset removed), the L1 set's replacement way and that entry exchange contents. No next-level request is made, the swap counter rises by one and no miss is counted. The line entering L1 is dirty if the request is a write or the entry was dirty; the line entering the buffer keeps its own dirty bit.
- R5: On a miss in both structures when the set has an invalid way, the lowest-numbered invalid way is filled and one refill read of the requested line is issued. The victim buffer is left unchanged.
- R6: On a miss in both structures with a full set and a victim buffer present, the buffer's replacement entry is chosen. If that entry is valid and dirty, a writeback of its line is issued first. The L1 replacement line then moves into that entry, the new line is installed, and a refill read follows.
- R7: With no victim buffer (VB_ENTRIES = 0), a miss on a full set evicts the L1 replacement line. If that line is dirty it is written back first, then the requested line is read.
- R8: Each way and each victim entry has an age counter of AGE_W bits. On every access that touches a structure, the touched slot's age becomes 0 and every other slot's age rises by one, saturating at all ones. The replacement slot is the lowest-numbered invalid slot if there is one; otherwise it is the slot with the largest age, with the lower index winning ties.
- R9: The counters hold:
  - reads and writes accepted, each rising once per accepted request of that kind;
  - read misses and write misses, counted only when both structures miss;
  - writebacks issued;
  - victim swaps.
- R10: `req_ready` is low while a next-level request is outstanding. A next-level request holds its address and write flag until `mem_ack`. A writeback (`mem_req_write` = 1) always precedes the refill read (`mem_req_write` = 0) of the same miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| mem_req_valid | output | 1 | Next-level request outstanding |
| mem_req_write | output | 1 | 1 = writeback, 0 = refill read |
| mem_req_addr | output | ADDR_W | Line address, offset bits zero |
| mem_ack | input | 1 | Next level completes the current request |
| cnt_reads | output | CNT_W | Reads accepted |
| cnt_read_misses | output | CNT_W | Reads missing L1 and victim buffer |
| cnt_writes | output | CNT_W | Writes accepted |
| cnt_write_misses | output | CNT_W | Writes missing L1 and victim buffer |
| cnt_writebacks | output | CNT_W | Writebacks issued |
| cnt_swaps | output | CNT_W | L1/victim exchanges |

## Verification
A wrong age, dirty bit or tag inside the controller stays hidden until the set or the buffer next has to choose what to evict. At that point it appears on the next-level port as a missing, extra or misaddressed writeback, or as a refill where a swap was due. It can also appear as a miss or swap counter that disagrees by one. The bench keeps its own model of every tag, dirty bit and age. It compares each next-level transaction and all six counters after every request, so a corrupted state is reported at the first request that reaches it. Dense conflict traffic on a small configuration reaches eviction within a few requests.

// File: rtl/l1vb_pkg.sv
package l1vb_pkg;

    typedef enum logic [1:0] {
        MC_IDLE = 2'd0,
        MC_WB   = 2'd1,
        MC_RD   = 2'd2
    } mc_state_e;

endpackage

// File: rtl/l1vb_pick.sv
// Replacement choice: lowest invalid slot, else oldest slot (lowest index on ties).
module l1vb_pick #(
    parameter int N     = 2,
    parameter int AGE_W = 4,
    parameter int IX_W  = 1
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic [IX_W-1:0]         sel,
    output logic                    free
);
    always_comb begin
        logic [AGE_W-1:0] best;
        sel  = '0;
        free = 1'b0;
        best = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                sel  = IX_W'(i);
                free = 1'b1;
            end
        end
        if (!free) begin
            best = age[0];
            for (int i = 1; i < N; i++) begin
                if (age[i] > best) begin
                    best = age[i];
                    sel  = IX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/l1vb_match.sv
// Parallel tag compare across N slots.
module l1vb_match #(
    parameter int N    = 2,
    parameter int W    = 8,
    parameter int IX_W = 1
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic                hit,
    output logic [IX_W-1:0]     idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = IX_W'(i);
            end
        end
    end
endmodule

// File: rtl/l1vb_cache.sv
module l1vb_cache
    import l1vb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16,
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int VB_ENTRIES  = 4,
    parameter int AGE_W       = 4,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  cnt_reads,
    output logic [CNT_W-1:0]  cnt_read_misses,
    output logic [CNT_W-1:0]  cnt_writes,
    output logic [CNT_W-1:0]  cnt_write_misses,
    output logic [CNT_W-1:0]  cnt_writebacks,
    output logic [CNT_W-1:0]  cnt_swaps
);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam bit HAS_VB = (VB_ENTRIES > 0);
    localparam int VB_N   = HAS_VB ? VB_ENTRIES : 1;
    localparam int WIX_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int VIX_W  = (VB_N > 1) ? $clog2(VB_N) : 1;

    typedef logic [WAYS-1:0][AGE_W-1:0] way_age_t;
    typedef logic [VB_N-1:0][AGE_W-1:0] vb_age_t;

    typedef struct packed {
        mc_state_e                          st;
        logic [SETS-1:0][WAYS-1:0]          l1_v;
        logic [SETS-1:0][WAYS-1:0]          l1_d;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] l1_tag;
        logic [SETS-1:0]                    unused_pad;
        way_age_t [SETS-1:0]                l1_age;
        logic [VB_N-1:0]                    vb_v;
        logic [VB_N-1:0]                    vb_d;
        logic [VB_N-1:0][LINE_W-1:0]        vb_tag;
        vb_age_t                            vb_age;
        logic [LINE_W-1:0]                  wb_line;
        logic [LINE_W-1:0]                  rd_line;
        logic [CNT_W-1:0]                   c_rd;
        logic [CNT_W-1:0]                   c_rm;
        logic [CNT_W-1:0]                   c_wr;
        logic [CNT_W-1:0]                   c_wm;
        logic [CNT_W-1:0]                   c_wb;
        logic [CNT_W-1:0]                   c_sw;
    } state_t;

    state_t q, d;

    // R1: address fields
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic [LINE_W-1:0] a_line;
    logic              unused_offset;
    assign a_idx         = req_addr[OFF_W +: IDX_W];
    assign a_tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign a_line        = req_addr[ADDR_W-1 -: LINE_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    logic              l1_hit, l1_free, vb_hit_raw, vb_hit, vb_free_unused;
    logic [WIX_W-1:0]  hit_way, lru_way;
    logic [VIX_W-1:0]  vb_hit_ix, vb_sel;
    logic              accept;

    l1vb_match #(.N(WAYS), .W(TAG_W), .IX_W(WIX_W)) u_l1_match (
        .vld(q.l1_v[a_idx]), .tags(q.l1_tag[a_idx]), .key(a_tag),
        .hit(l1_hit), .idx(hit_way)
    );
    l1vb_pick #(.N(WAYS), .AGE_W(AGE_W), .IX_W(WIX_W)) u_l1_pick (
        .vld(q.l1_v[a_idx]), .age(q.l1_age[a_idx]), .sel(lru_way), .free(l1_free)
    );
    l1vb_match #(.N(VB_N), .W(LINE_W), .IX_W(VIX_W)) u_vb_match (
        .vld(q.vb_v), .tags(q.vb_tag), .key(a_line),
        .hit(vb_hit_raw), .idx(vb_hit_ix)
    );
    l1vb_pick #(.N(VB_N), .AGE_W(AGE_W), .IX_W(VIX_W)) u_vb_pick (
        .vld(q.vb_v), .age(q.vb_age), .sel(vb_sel), .free(vb_free_unused)
    );

    assign vb_hit = HAS_VB && vb_hit_raw;

    // R8: touched slot to zero, others age by one with saturation
    function automatic way_age_t touch_way(input way_age_t a, input logic [WIX_W-1:0] t);
        way_age_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (WIX_W'(i) == t)  r[i] = '0;
            else if (&a[i])      r[i] = a[i];
            else                 r[i] = a[i] + 1'b1;
        end
        return r;
    endfunction

    function automatic vb_age_t touch_vb(input vb_age_t a, input logic [VIX_W-1:0] t);
        vb_age_t r;
        for (int i = 0; i < VB_N; i++) begin
            if (VIX_W'(i) == t)  r[i] = '0;
            else if (&a[i])      r[i] = a[i];
            else                 r[i] = a[i] + 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        d         = q;
        req_ready = (q.st == MC_IDLE);
        accept    = req_valid && req_ready;

        case (q.st)
            MC_WB:   if (mem_ack) d.st = MC_RD;
            MC_RD:   if (mem_ack) d.st = MC_IDLE;
            default: ;
        endcase

        if (accept) begin
            if (req_write) d.c_wr = q.c_wr + 1'b1;
            else           d.c_rd = q.c_rd + 1'b1;

            if (l1_hit) begin
                // R3
                d.l1_d[a_idx][hit_way] = q.l1_d[a_idx][hit_way] | req_write;
                d.l1_age[a_idx]        = touch_way(q.l1_age[a_idx], hit_way);
            end else if (vb_hit) begin
                // R4: exchange L1 replacement way with matching entry
                d.l1_v[a_idx][lru_way]   = 1'b1;
                d.l1_d[a_idx][lru_way]   = req_write | q.vb_d[vb_hit_ix];
                d.l1_tag[a_idx][lru_way] = q.vb_tag[vb_hit_ix][LINE_W-1 -: TAG_W];
                d.vb_v[vb_hit_ix]        = q.l1_v[a_idx][lru_way];
                d.vb_d[vb_hit_ix]        = q.l1_d[a_idx][lru_way];
                d.vb_tag[vb_hit_ix]      = {q.l1_tag[a_idx][lru_way], a_idx};
                d.l1_age[a_idx]          = touch_way(q.l1_age[a_idx], lru_way);
                d.vb_age                 = touch_vb(q.vb_age, vb_hit_ix);
                d.c_sw                   = q.c_sw + 1'b1;
            end else begin
                if (req_write) d.c_wm = q.c_wm + 1'b1;
                else           d.c_rm = q.c_rm + 1'b1;
                d.rd_line = a_line;
                d.st      = MC_RD;
                if (!l1_free) begin
                    if (HAS_VB) begin
                        // R6
                        if (q.vb_v[vb_sel] && q.vb_d[vb_sel]) begin
                            d.wb_line = q.vb_tag[vb_sel];
                            d.st      = MC_WB;
                            d.c_wb    = q.c_wb + 1'b1;
                        end
                        d.vb_v[vb_sel]   = 1'b1;
                        d.vb_d[vb_sel]   = q.l1_d[a_idx][lru_way];
                        d.vb_tag[vb_sel] = {q.l1_tag[a_idx][lru_way], a_idx};
                        d.vb_age         = touch_vb(q.vb_age, vb_sel);
                    end else if (q.l1_d[a_idx][lru_way]) begin
                        // R7
                        d.wb_line = {q.l1_tag[a_idx][lru_way], a_idx};
                        d.st      = MC_WB;
                        d.c_wb    = q.c_wb + 1'b1;
                    end
                end
                // R5/R6/R7: install requested line
                d.l1_v[a_idx][lru_way]   = 1'b1;
                d.l1_d[a_idx][lru_way]   = req_write;
                d.l1_tag[a_idx][lru_way] = a_tag;
                d.l1_age[a_idx]          = touch_way(q.l1_age[a_idx], lru_way);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;   // R2
        else        q <= d;
    end

    assign mem_req_valid    = (q.st != MC_IDLE);
    assign mem_req_write    = (q.st == MC_WB);
    assign mem_req_addr     = {((q.st == MC_WB) ? q.wb_line : q.rd_line), {OFF_W{1'b0}}};
    assign cnt_reads        = q.c_rd;
    assign cnt_read_misses  = q.c_rm;
    assign cnt_writes       = q.c_wr;
    assign cnt_write_misses = q.c_wm;
    assign cnt_writebacks   = q.c_wb;
    assign cnt_swaps        = q.c_sw;

endmodule

// File: rtl/l1vb_cache_chk.sv
module l1vb_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_ack,
    input logic [CNT_W-1:0]  cnt_reads,
    input logic [CNT_W-1:0]  cnt_writes,
    input logic [CNT_W-1:0]  cnt_read_misses,
    input logic [CNT_W-1:0]  cnt_write_misses,
    input logic [CNT_W-1:0]  cnt_swaps
);
    logic [CNT_W-1:0] miss_sum;
    assign miss_sum = cnt_read_misses + cnt_write_misses;

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ack) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_wb_then_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_ack) |=> (mem_req_valid && !mem_req_write));

    assert_miss_goes_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid == (miss_sum != $past(miss_sum))));

    assert_swap_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_swaps) |-> !mem_req_valid);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(cnt_reads - $past(cnt_reads)) <= CNT_W'(1)) &&
        (CNT_W'(cnt_writes - $past(cnt_writes)) <= CNT_W'(1)));

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[0] == 1'b0));
endmodule

bind l1vb_cache l1vb_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_ack(mem_ack),
    .cnt_reads(cnt_reads), .cnt_writes(cnt_writes),
    .cnt_read_misses(cnt_read_misses), .cnt_write_misses(cnt_write_misses),
    .cnt_swaps(cnt_swaps)
);

// File: tb/l1vb_cache_tb.sv
module l1vb_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AMAX       = 15;   // saturated age for AGE_W = 4

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_write;
    logic [7:0] req_addr;
    logic rdy   [2];
    logic mem_v [2];
    logic mem_w [2];
    logic [7:0] mem_a [2];
    logic ack   [2];
    logic [15:0] cnt [2][6];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // k = 0: two victim entries; k = 1: no victim buffer
    l1vb_cache #(.ADDR_W(8), .BLOCK_BYTES(4), .SETS(4), .WAYS(2), .VB_ENTRIES(2),
                 .AGE_W(4), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
        .req_write(req_write), .req_addr(req_addr),
        .mem_req_valid(mem_v[0]), .mem_req_write(mem_w[0]), .mem_req_addr(mem_a[0]),
        .mem_ack(ack[0]),
        .cnt_reads(cnt[0][0]), .cnt_read_misses(cnt[0][1]), .cnt_writes(cnt[0][2]),
        .cnt_write_misses(cnt[0][3]), .cnt_writebacks(cnt[0][4]), .cnt_swaps(cnt[0][5])
    );

    l1vb_cache #(.ADDR_W(8), .BLOCK_BYTES(4), .SETS(4), .WAYS(2), .VB_ENTRIES(0),
                 .AGE_W(4), .CNT_W(16)) u_dut_nv (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
        .req_write(req_write), .req_addr(req_addr),
        .mem_req_valid(mem_v[1]), .mem_req_write(mem_w[1]), .mem_req_addr(mem_a[1]),
        .mem_ack(ack[1]),
        .cnt_reads(cnt[1][0]), .cnt_read_misses(cnt[1][1]), .cnt_writes(cnt[1][2]),
        .cnt_write_misses(cnt[1][3]), .cnt_writebacks(cnt[1][4]), .cnt_swaps(cnt[1][5])
    );

    // bench model
    bit m_v  [2][4][2];
    bit m_d  [2][4][2];
    int m_t  [2][4][2];
    int m_a  [2][4][2];
    bit m_vv [2][2];
    bit m_vd [2][2];
    int m_vt [2][2];
    int m_va [2][2];
    int exp_c [2][6];

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++) begin
                    m_v[k][s][w] = 0; m_d[k][s][w] = 0; m_t[k][s][w] = 0; m_a[k][s][w] = 0;
                end
            for (int e = 0; e < 2; e++) begin
                m_vv[k][e] = 0; m_vd[k][e] = 0; m_vt[k][e] = 0; m_va[k][e] = 0;
            end
            for (int c = 0; c < 6; c++) exp_c[k][c] = 0;
        end
    endtask

    // R8 ageing rule
    task automatic touch_l1(input int k, input int s, input int w);
        for (int i = 0; i < 2; i++)
            if (i == w) m_a[k][s][i] = 0;
            else if (m_a[k][s][i] < AMAX) m_a[k][s][i]++;
    endtask

    task automatic touch_vb(input int k, input int e);
        for (int i = 0; i < 2; i++)
            if (i == e) m_va[k][i] = 0;
            else if (m_va[k][i] < AMAX) m_va[k][i]++;
    endtask

    task automatic model_step(input int k, input bit wr, input logic [7:0] a,
                              output bit ewb, output logic [7:0] ewa,
                              output bit erd, output logic [7:0] era);
        int s, t, ln, hw, vh, lw, vw, nvb, old_ln;
        bit old_d;
        s = int'(a[3:2]); t = int'(a[7:4]); ln = int'(a[7:2]);
        nvb = (k == 0) ? 2 : 0;
        ewb = 0; erd = 0; ewa = '0; era = '0; hw = -1; vh = -1;
        if (wr) exp_c[k][2]++; else exp_c[k][0]++;
        for (int w = 0; w < 2; w++) if (m_v[k][s][w] && m_t[k][s][w] == t) hw = w;
        for (int e = 0; e < nvb; e++) if (m_vv[k][e] && m_vt[k][e] == ln) vh = e;
        lw = -1;
        for (int w = 0; w < 2; w++) if (!m_v[k][s][w] && lw < 0) lw = w;
        if (lw < 0) begin
            lw = 0;
            for (int w = 1; w < 2; w++) if (m_a[k][s][w] > m_a[k][s][lw]) lw = w;
        end
        vw = -1;
        for (int e = 0; e < 2; e++) if (!m_vv[k][e] && vw < 0) vw = e;
        if (vw < 0) begin
            vw = 0;
            if (m_va[k][1] > m_va[k][0]) vw = 1;
        end
        if (hw >= 0) begin
            if (wr) m_d[k][s][hw] = 1;
            touch_l1(k, s, hw);
        end else if (vh >= 0) begin
            old_ln = m_t[k][s][lw] * 4 + s;
            old_d  = m_d[k][s][lw];
            m_t[k][s][lw] = m_vt[k][vh] / 4;
            m_d[k][s][lw] = wr | m_vd[k][vh];
            m_vv[k][vh] = m_v[k][s][lw];
            m_v[k][s][lw] = 1;
            m_vt[k][vh] = old_ln;
            m_vd[k][vh] = old_d;
            touch_l1(k, s, lw);
            touch_vb(k, vh);
            exp_c[k][5]++;
        end else begin
            if (wr) exp_c[k][3]++; else exp_c[k][1]++;
            erd = 1; era = 8'(ln * 4);
            if (m_v[k][s][lw]) begin
                if (nvb > 0) begin
                    if (m_vv[k][vw] && m_vd[k][vw]) begin
                        ewb = 1; ewa = 8'(m_vt[k][vw] * 4); exp_c[k][4]++;
                    end
                    m_vv[k][vw] = 1;
                    m_vd[k][vw] = m_d[k][s][lw];
                    m_vt[k][vw] = m_t[k][s][lw] * 4 + s;
                    touch_vb(k, vw);
                end else if (m_d[k][s][lw]) begin
                    ewb = 1; ewa = 8'((m_t[k][s][lw] * 4 + s) * 4); exp_c[k][4]++;
                end
            end
            m_v[k][s][lw] = 1; m_d[k][s][lw] = wr; m_t[k][s][lw] = t;
            touch_l1(k, s, lw);
        end
    endtask

    // Next-level responder; entered at the falling edge after acceptance.
    task automatic serve(input int k, input bit ewb, input logic [7:0] ewa,
                         input bit erd, input logic [7:0] era, input bit stall);
        string wtag;
        wtag = (k == 0) ? "R6 writeback address (R1)" : "R7 writeback address (R1)";
        if (ewb) begin
            chk(mem_v[k] && mem_w[k], "R10 writeback issued before refill", {mem_v[k], mem_w[k]}, 3);
            chk(mem_a[k] == ewa, wtag, mem_a[k], ewa);
            chk(!rdy[k], "R10 ready low while writeback outstanding", rdy[k], 0);
            if (stall) begin
                @(negedge clk);
                chk(mem_v[k] && mem_w[k] && mem_a[k] == ewa, "R10 writeback held until ack",
                    mem_a[k], ewa);
            end
            ack[k] = 1'b1;
            @(negedge clk);
            ack[k] = 1'b0;
        end
        if (erd) begin
            chk(mem_v[k] && !mem_w[k], "R5 refill read issued", {mem_v[k], mem_w[k]}, 2);
            chk(mem_a[k] == era, "R5/R6 refill line address (R1)", mem_a[k], era);
            chk(!rdy[k], "R10 ready low while refill outstanding", rdy[k], 0);
            if (stall) begin
                @(negedge clk);
                chk(mem_v[k] && !mem_w[k] && mem_a[k] == era, "R10 refill held until ack",
                    mem_a[k], era);
            end
            ack[k] = 1'b1;
            @(negedge clk);
            ack[k] = 1'b0;
        end
        chk(rdy[k] && !mem_v[k], "R3/R4 no outstanding request and ready after access",
            {rdy[k], mem_v[k]}, 2);
    endtask

    task automatic check_counters();
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 6; c++)
                chk(cnt[k][c] == 16'(exp_c[k][c]), $sformatf("R9 counter %0d of dut %0d", c, k),
                    cnt[k][c], exp_c[k][c]);
    endtask

    task automatic do_req(input bit wr, input logic [7:0] a, input bit stall);
        bit ewb0, erd0, ewb1, erd1;
        logic [7:0] ewa0, era0, ewa1, era1;
        model_step(0, wr, a, ewb0, ewa0, erd0, era0);
        model_step(1, wr, a, ewb1, ewa1, erd1, era1);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        fork
            serve(0, ewb0, ewa0, erd0, era0, stall);
            serve(1, ewb1, ewa1, erd1, era1, stall);
        join
        check_counters();
    endtask

    task automatic reset_checks();
        for (int k = 0; k < 2; k++) begin
            chk(rdy[k] == 1'b1, "R2 ready after reset", rdy[k], 1);
            chk(mem_v[k] == 1'b0, "R2 no next-level request after reset", mem_v[k], 0);
        end
        check_counters();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        ack[0] = 1'b0; ack[1] = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();   // R2

        // directed: set 0 fills (R5), hit (R3), eviction (R6/R7), swap (R4), dirty swap
        do_req(1'b1, 8'h10, 1'b0);
        do_req(1'b1, 8'h20, 1'b0);
        do_req(1'b0, 8'h11, 1'b0);
        do_req(1'b0, 8'h30, 1'b1);
        do_req(1'b0, 8'h22, 1'b0);
        chk(cnt[0][5] == 16'd1, "R4 one swap on victim hit", cnt[0][5], 1);
        chk(cnt[1][4] == 16'd2, "R7 dirty evictions written back", cnt[1][4], 2);
        do_req(1'b1, 8'h13, 1'b0);
        do_req(1'b0, 8'h40, 1'b1);
        do_req(1'b0, 8'h50, 1'b0);
        do_req(1'b0, 8'h60, 1'b0);

        // sweep every byte address with a mix of reads and writes
        for (int n = 0; n < 256; n++)
            do_req(n[2] ^ n[5], 8'(n), n[0]);

        // dense conflict traffic: eight tags over four sets
        lf = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_req(lf[7], {1'b0, lf[2:0], lf[4:3], lf[6:5]}, lf[8]);
        end

        // R2: reset discards all contents and counts
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        reset_checks();
        do_req(1'b0, 8'h10, 1'b0);
        chk(cnt[0][1] == 16'd1, "R2 previously cached line misses after reset", cnt[0][1], 1);
        do_req(1'b0, 8'h20, 1'b0);
        do_req(1'b0, 8'h30, 1'b0);
        chk(cnt[1][4] == 16'd0, "R2 no writeback of pre-reset dirty lines", cnt[1][4], 0);

        finish_run();
    end
endmodule